// File: doc/BRIEF.md
# Serial ADC Control Interface Model

This block is a synthesizable model of the digital side of an eight-input serial converter. A host drives a serial clock, an active-low select and a data line. When it sends a start bit followed by a seven-bit control word, the block latches the channel, the polarity, the input mode and the power mode. It then starts a conversion, skips it, or keeps the converter off, depending on the power mode and the shutdown pin. No analog behaviour is modelled. The result of a conversion is taken from a parallel input that holds one frame per channel, indexed by the latched channel. The result leaves on a serial data line, most significant bit first, followed by zeros.

Two clock modes exist. In the internal one, a cycle counter stands in for the conversion time. The strobe output is low while the counter runs and returns high when the frame is ready. In the external one, the host's serial clock paces acquisition, and the strobe announces the first result bit one serial period in advance. The serial clock, select and data inputs are sampled with the block's own system clock. The serial clock passes through a synchronizer, and its edges are detected from the synchronized copy.

Top module: `adc_serial_if`

## Requirements
- R1: After reset the strobe is high, `pwr_state` is 2'b00 (powered, internal clock mode), and with `cs_n` low `dout` reads 0 until a conversion has loaded a frame.
- R2: While `cs_n` is low, rising serial edges with data 0 are ignored until the first 1. That 1 is the start bit. The next seven bits, in order, are channel bit 2, bit 1, bit 0, unipolar, single-ended, power bit 1 and power bit 0. `chan_o`, `unipolar_o` and `single_o` take the new values once the last bit has been received.
- R3: The power bits select the mode: 2'b11 is external clock, 2'b10 is internal clock, 2'b01 is fast power-down and 2'b00 is full power-down. `pwr_state` reports 2'b00 for either clock mode, 2'b01 for fast power-down and 2'b10 for full power-down.
- R4: In internal clock mode the strobe goes low when the last control bit is latched. It stays low for exactly CONV_CYCLES system clock cycles, then returns high with the first result bit on `dout`.
- R5: The frame for the selected channel leaves on `dout` as ten data bits and then two sub-bits, most significant first. Each serial falling edge advances it by one bit, and zeros follow the last bit.
- R6: In external clock mode the strobe goes high on the ACQ_SCLKS-th serial falling edge after the last control bit. It goes low again on the next falling edge, and that edge puts the first result bit on `dout`.
- R7: A word that selects fast or full power-down updates the latched configuration but starts no conversion: the strobe level and `dout` stay as they were.
- R8: While `shdn_n` is low, `pwr_state` is 2'b10 whatever the power bits, and no conversion starts. Pulling `shdn_n` low during a conversion aborts it without a frame being loaded and sets the strobe high.
- R9: While `cs_n` is high, `dout_oe` is low and a partly received control word is discarded.
- R10: Serial edges that arrive during acquisition or conversion are not parsed, so a 1 on `din` there does not begin a control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also times the internal conversion |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial control data, sampled on rising serial edges |
| shdn_n | input | 1 | Active-low hard shutdown |
| sample_i | input | 8*(RES_W+SUB_W) | Result frame per channel; channel k occupies bits k*(RES_W+SUB_W) upward |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (high while selected) |
| strobe | output | 1 | Conversion status strobe |
| pwr_state | output | 2 | 00 powered, 01 fast power-down, 10 full power-down |
| chan_o | output | 3 | Latched channel |
| unipolar_o | output | 1 | Latched polarity bit |
| single_o | output | 1 | Latched input mode bit |

## Verification
The bench builds the block with CONV_CYCLES=24 and ACQ_SCLKS=2, and keeps the default frame of ten data bits plus two sub-bits. With a conversion this short, every one of the eight channels can be swept in both clock modes, each with its own computed frame. The bench can also count the strobe-low window cycle by cycle. An ACQ_SCLKS of two leaves one serial edge inside acquisition on which a 1 is driven on `din`, which shows that the parser is gated off there. The conversion is also short enough for an abort in the middle of it to be reached after an ordinary control word.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

  localparam int CH_W = 3;
  localparam int NCH  = 1 << CH_W;

  typedef enum logic [1:0] {
    PM_FULL = 2'b00,
    PM_FAST = 2'b01,
    PM_INT  = 2'b10,
    PM_EXT  = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    PS_ON   = 2'b00,
    PS_FAST = 2'b01,
    PS_OFF  = 2'b10
  } pstate_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACQ,
    PH_ANN,
    PH_CONV
  } phase_e;

  // field order equals the order of bits on the wire after the start bit
  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            unipolar;
    logic            single;
    pmode_e          pmode;
  } ctl_t;

endpackage

// File: rtl/adc_if_edge.sv
module adc_if_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], sclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise = ~cs_n &  sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign fall = ~cs_n & ~sync_q[SYNC_STAGES-1] &  sync_q[SYNC_STAGES];

endmodule

// File: rtl/adc_if_parser.sv
module adc_if_parser
  import adc_if_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic en,
  input  logic rise,
  input  logic din,
  output logic valid,
  output ctl_t word
);

  logic [2:0] cnt_q, cnt_d;
  logic [5:0] sr_q, sr_d;
  logic       valid_d;
  ctl_t       word_d;

  always_comb begin
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    valid_d = 1'b0;
    word_d  = word;
    if (cs_n) begin
      cnt_d = '0;
    end else if (rise && en) begin
      if (cnt_q == 3'd0) begin
        if (din) cnt_d = 3'd1;
      end else if (cnt_q == 3'd7) begin
        valid_d = 1'b1;
        word_d  = ctl_t'({sr_q, din});
        cnt_d   = '0;
      end else begin
        sr_d  = {sr_q[4:0], din};
        cnt_d = cnt_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
      valid <= 1'b0;
      word  <= ctl_t'({3'd0, 1'b0, 1'b0, PM_INT});
    end else begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
      valid <= valid_d;
      word  <= word_d;
    end
  end

  // R2 / R9 / R10: a word completes only from a selected, enabled edge
  p_word_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(!cs_n && en));

endmodule

// File: rtl/adc_if_seq.sv
module adc_if_seq
  import adc_if_pkg::*;
#(
  parameter int CONV_CYCLES = 400,
  parameter int ACQ_SCLKS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic valid,
  input  ctl_t word,
  input  logic fall,
  output logic busy,
  output logic load,
  output logic strobe,
  output ctl_t cfg
);

  localparam int CMAX  = (CONV_CYCLES > ACQ_SCLKS) ? CONV_CYCLES : ACQ_SCLKS;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_SCLKS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             strobe_d, load_d;
  ctl_t             cfg_d;
  logic             go;

  assign go = valid && shdn_n;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    strobe_d = strobe;
    load_d   = 1'b0;
    cfg_d    = valid ? word : cfg;
    unique case (phase_q)
      PH_IDLE: begin
        if (go && word.pmode == PM_EXT) begin
          phase_d  = PH_ACQ;
          cnt_d    = '0;
          strobe_d = 1'b0;
        end else if (go && word.pmode == PM_INT) begin
          phase_d  = PH_CONV;
          cnt_d    = '0;
          strobe_d = 1'b0;
        end
      end
      PH_ACQ: begin
        if (fall) begin
          if (cnt_q == ACQ_LAST) begin
            phase_d  = PH_ANN;
            strobe_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_ANN: begin
        if (fall) begin
          phase_d  = PH_IDLE;
          strobe_d = 1'b0;
          load_d   = 1'b1;
        end
      end
      PH_CONV: begin
        if (cnt_q == CONV_LAST) begin
          phase_d  = PH_IDLE;
          strobe_d = 1'b1;
          load_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (!shdn_n && phase_q != PH_IDLE) begin
      phase_d  = PH_IDLE;
      strobe_d = 1'b1;
      load_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      strobe  <= 1'b1;
      load    <= 1'b0;
      cfg     <= ctl_t'({3'd0, 1'b0, 1'b0, PM_INT});
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      strobe  <= strobe_d;
      load    <= load_d;
      cfg     <= cfg_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);

  p_strobe_low_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_CONV |-> !strobe);

  p_strobe_fell_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> $past(valid) || $past(phase_q == PH_ANN));

  p_ann_then_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_ANN && fall && shdn_n |=> load);

  p_pd_no_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !word.pmode[1] |=> phase_q == PH_IDLE);

  p_shdn_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> !load);

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(cfg));

endmodule

// File: rtl/adc_if_shift.sv
module adc_if_shift #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               fall,
  output logic               bit_o
);

  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)      sh_d = frame;
    else if (fall) sh_d = {sh_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign bit_o = sh_q[FRAME_W-1];

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !fall |=> $stable(sh_q));

  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !load |=> !sh_q[0]);

endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_if_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SUB_W       = 2,
  parameter int CONV_CYCLES = 400,
  parameter int ACQ_SCLKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           arst_n,
  input  logic                           sclk,
  input  logic                           cs_n,
  input  logic                           din,
  input  logic                           shdn_n,
  input  logic [NCH*(RES_W+SUB_W)-1:0]   sample_i,
  output logic                           dout,
  output logic                           dout_oe,
  output logic                           strobe,
  output logic [1:0]                     pwr_state,
  output logic [CH_W-1:0]                chan_o,
  output logic                           unipolar_o,
  output logic                           single_o
);

  localparam int FRAME_W = RES_W + SUB_W;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [FRAME_W-1:0] smp [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign smp[g] = sample_i[g*FRAME_W +: FRAME_W];
  end

  logic rise, fall, valid, busy, load;
  ctl_t word, cfg;

  adc_if_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .rise(rise), .fall(fall));

  adc_if_parser u_parser (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en(!busy), .rise(rise),
    .din(din), .valid(valid), .word(word));

  adc_if_seq #(.CONV_CYCLES(CONV_CYCLES), .ACQ_SCLKS(ACQ_SCLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .valid(valid), .word(word),
    .fall(fall), .busy(busy), .load(load), .strobe(strobe), .cfg(cfg));

  adc_if_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .frame(smp[cfg.chan]),
    .fall(fall), .bit_o(dout));

  always_comb begin
    if (!shdn_n) begin
      pwr_state = PS_OFF;
    end else begin
      unique case (cfg.pmode)
        PM_FULL: pwr_state = PS_OFF;
        PM_FAST: pwr_state = PS_FAST;
        default: pwr_state = PS_ON;
      endcase
    end
  end

  assign dout_oe    = ~cs_n;
  assign chan_o     = cfg.chan;
  assign unipolar_o = cfg.unipolar;
  assign single_o   = cfg.single;

  p_oe_strobe_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> strobe);

endmodule

// File: tb/adc_serial_if_tb.sv
module adc_serial_if_tb;

  localparam int RES_W = 10;
  localparam int SUB_W = 2;
  localparam int FW    = RES_W + SUB_W;
  localparam int CONV  = 24;
  localparam int ACQ   = 2;
  localparam int H     = 6;

  logic clk = 1'b0;
  logic arst_n, sclk, cs_n, din, shdn_n;
  logic [8*FW-1:0] sample;
  logic dout, dout_oe, strobe, unipolar_o, single_o;
  logic [1:0] pwr_state;
  logic [2:0] chan_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  adc_serial_if #(.RES_W(RES_W), .SUB_W(SUB_W), .CONV_CYCLES(CONV),
                  .ACQ_SCLKS(ACQ)) u_dut (
    .clk(clk), .arst_n(arst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .shdn_n(shdn_n), .sample_i(sample), .dout(dout), .dout_oe(dout_oe),
    .strobe(strobe), .pwr_state(pwr_state), .chan_o(chan_o),
    .unipolar_o(unipolar_o), .single_o(single_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pat(input int ch, input int rnd);
    return FW'((ch + 1) * 727 + rnd * 317) ^ FW'(12'hA5A);
  endfunction

  task automatic set_samples(input int rnd);
    for (int c = 0; c < 8; c++) sample[c*FW +: FW] = pat(c, rnd);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    din = d; sclk = 1'b1; waitc(H);
    sclk = 1'b0; waitc(H);
  endtask

  // start bit plus the first six control bits
  task automatic send_head(input logic [6:0] w);
    pulse(1'b1);
    for (int i = 6; i >= 1; i--) pulse(w[i]);
  endtask

  task automatic send_word(input logic [6:0] w);
    send_head(w);
    pulse(w[0]);
    din = 1'b0;
  endtask

  task automatic readout(input logic [FW-1:0] f, input string tag);
    chk(tag, dout, f[FW-1]);
    for (int i = FW - 2; i >= 0; i--) begin
      pulse(1'b0);
      chk(tag, dout, f[i]);
    end
    pulse(1'b0);
    chk({tag, " zero fill"}, dout, 1'b0);
    pulse(1'b0);
    chk({tag, " zero fill"}, dout, 1'b0);
  endtask

  task automatic int_conv(input logic [2:0] ch, input int rnd);
    logic [6:0] w;
    int n, t;
    w = {ch, ch[0], ch[1], 2'b10};
    set_samples(rnd);
    send_head(w);
    din = w[0]; sclk = 1'b1;
    t = 0;
    while (strobe && t < 40) begin @(negedge clk); t++; end
    sclk = 1'b0;
    n = 0;
    while (!strobe && n < 1000) begin n++; @(negedge clk); end
    chk("R4 strobe low cycles", n, CONV);
    waitc(3);
    chk("R2 channel", chan_o, ch);
    chk("R2 unipolar", unipolar_o, ch[0]);
    chk("R2 single", single_o, ch[1]);
    chk("R3 powered", pwr_state, 2'b00);
    readout(pat(ch, rnd), "R5 internal frame");
  endtask

  task automatic ext_conv(input logic [2:0] ch, input int rnd);
    logic [6:0] w;
    w = {ch, ~ch[0], ch[2], 2'b11};
    set_samples(rnd);
    send_word(w);
    chk("R6 strobe low in acquisition", strobe, 1'b0);
    for (int k = 1; k < ACQ; k++) begin
      pulse(1'b1);   // R10: a 1 here must not start a word
    end
    chk("R6 strobe announces", strobe, 1'b1);
    pulse(1'b1);
    chk("R6 strobe drops with MSB", strobe, 1'b0);
    chk("R2 channel ext", chan_o, ch);
    readout(pat(ch, rnd), "R6 R5 external frame");
    chk("R10 no word parsed in acquisition", pwr_state, 2'b00);
  endtask

  initial begin
    arst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0; shdn_n = 1'b1;
    sample = '0;
    waitc(5);
    arst_n = 1'b1;
    waitc(5);
    chk("R1 strobe after reset", strobe, 1'b1);
    chk("R1 pwr_state after reset", pwr_state, 2'b00);
    chk("R9 oe low while deselected", dout_oe, 1'b0);
    cs_n = 1'b0;
    waitc(2);
    chk("R9 oe high while selected", dout_oe, 1'b1);
    set_samples(0);
    for (int i = 0; i < 3; i++) pulse(1'b0);   // R2 leading zeros
    chk("R1 dout zero before conversion", dout, 1'b0);
    chk("R2 leading zeros ignored", pwr_state, 2'b00);

    for (int c = 0; c < 8; c++) int_conv(3'(c), c + 1);
    for (int c = 0; c < 8; c++) ext_conv(3'(c), c + 11);

    // R7: power-down words, strobe currently low
    sample = '1;
    send_word({3'd5, 1'b1, 1'b0, 2'b01});
    chk("R3 fast power-down", pwr_state, 2'b01);
    chk("R7 config updated", chan_o, 3'd5);
    waitc(CONV + 10);
    chk("R7 strobe unchanged", strobe, 1'b0);
    chk("R7 no frame", dout, 1'b0);
    send_word({3'd3, 1'b0, 1'b1, 2'b00});
    chk("R3 full power-down", pwr_state, 2'b10);
    waitc(CONV + 10);
    chk("R7 strobe unchanged full", strobe, 1'b0);
    pulse(1'b0);
    chk("R7 no frame full", dout, 1'b0);

    // R8: shutdown blocks a conversion
    shdn_n = 1'b0;
    send_word({3'd1, 1'b0, 1'b0, 2'b10});
    chk("R8 shutdown overrides", pwr_state, 2'b10);
    waitc(CONV + 10);
    chk("R8 no conversion strobe", strobe, 1'b0);
    chk("R8 no conversion dout", dout, 1'b0);
    shdn_n = 1'b1;
    waitc(2);
    chk("R3 internal mode after release", pwr_state, 2'b00);
    send_word({3'd2, 1'b0, 1'b0, 2'b10});
    chk("R4 strobe low during conversion", strobe, 1'b0);
    shdn_n = 1'b0;
    waitc(4);
    chk("R8 abort sets strobe", strobe, 1'b1);
    waitc(CONV + 10);
    chk("R8 abort loads nothing", dout, 1'b0);
    shdn_n = 1'b1;
    waitc(2);

    // R7 with strobe high
    send_word({3'd4, 1'b0, 1'b0, 2'b01});
    waitc(CONV + 10);
    chk("R7 strobe stays high", strobe, 1'b1);
    chk("R7 dout stays zero", dout, 1'b0);

    // R9: partial word discarded on deselect
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    cs_n = 1'b1;
    waitc(3);
    chk("R9 oe low", dout_oe, 1'b0);
    cs_n = 1'b0;
    waitc(3);
    send_word({3'd6, 1'b0, 1'b1, 2'b01});
    chk("R9 channel after abort", chan_o, 3'd6);
    chk("R9 single after abort", single_o, 1'b1);
    chk("R9 unipolar after abort", unipolar_o, 1'b0);
    chk("R9 mode after abort", pwr_state, 2'b01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule